// File: doc/BRIEF.md
# Self-Triggered Column Acquisition Controller

This block controls the acquisition phase of a multichannel self-triggered readout chip. While an acquisition window is open, the OR of all per-channel trigger inputs starts an event capture. The capture takes the next free storage column, in order from column 0 upward. It pulses a hold strobe that names that column so the analog storage can freeze it. It stores the column's map of hit channels and the bunch-crossing count at that moment.

After a capture the trigger stays disarmed until the next bunch-crossing boundary, and then it rearms by itself. When every column has been used, the block saturates and ignores further triggers until a new acquisition starts. A trigger-inhibit input blocks captures. Triggers that arrive outside the window have no effect.

When the window closes, a one-cycle done pulse marks that the column count is valid for the conversion stage that follows. That stage reads back each column's map and stamp through a column select.

Top module: `evcol_acq_ctrl`

## Requirements
- R1: While armed, inside the window, with `no_trig` low and not saturated, any set bit of `trig_in` captures an event. In the next cycle `hold_strobe` is high for exactly one cycle.
- R2: Columns are taken in order 0, 1, 2 and so on. `hold_col` gives the captured column index, and `cols_used` gives the number of columns captured since the last `acq_start`. `acq_start` resets this count to 0.
- R3: Setting `rd_col` to a column index gives, on `rd_hits`, the full `trig_in` vector seen in that column's capture cycle, with bit i standing for channel i. `acq_start` clears every map to zero.
- R4: `rd_stamp` gives the crossing count sampled in the capture cycle. The crossing count is cleared by `acq_start` and goes up by one on each `bx_tick` cycle while the window is open. It wraps at its width.
- R5: After a capture, `armed` goes low. It returns high in the cycle after the first `bx_tick` that comes after the capture cycle. A tick in the capture cycle itself does not rearm.
- R6: Once all `N_COL` columns are used, `full` is high and `armed` is low. Further triggers change no map or stamp and give no hold strobe, until the next `acq_start`.
- R7: While `no_trig` is high, no capture occurs, and `armed` keeps its value.
- R8: Before the first `acq_start`, and after `acq_stop`, triggers produce no hold strobe and leave `cols_used` and all maps unchanged.
- R9: `acq_stop` during a window makes `acq_active` and `armed` go low and pulses `acq_done` for one cycle. No capture happens in the stop cycle. `cols_used` keeps its count until the next `acq_start`. If `acq_start` and `acq_stop` arrive in the same cycle, `acq_start` wins.
- R10: After reset, `acq_active`, `armed`, `full`, `hold_strobe` and `acq_done` are low, `cols_used` is 0, and every map and stamp reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Opens an acquisition window and clears columns |
| acq_stop | input | 1 | Closes the acquisition window |
| no_trig | input | 1 | Inhibits all captures while high |
| bx_tick | input | 1 | One-cycle bunch-crossing boundary pulse |
| trig_in | input | N_CH | Per-channel trigger inputs |
| rd_col | input | clog2(N_COL) | Column select for readback |
| acq_active | output | 1 | Acquisition window open |
| armed | output | 1 | Trigger armed |
| full | output | 1 | All columns used (saturated) |
| hold_strobe | output | 1 | One-cycle hold pulse for the captured column |
| hold_col | output | clog2(N_COL) | Index of the column last captured |
| cols_used | output | clog2(N_COL+1) | Columns captured in this acquisition |
| acq_done | output | 1 | One-cycle pulse at the end of the window |
| rd_hits | output | N_CH | Hit map of the selected column |
| rd_stamp | output | STAMP_W | Crossing stamp of the selected column |

## Verification
The bench targets several corner cases, each tied to the fault a wrong design would show:
- A tick in the same cycle as a capture. A design that rearmed on that tick would take a second column one crossing too early.
- The last column. A design with an off-by-one in the saturation test would either wrap over column 0 or stop one column short.
- `acq_stop`, or both `acq_start` and `acq_stop`, arriving together with a trigger. A wrong priority would capture after the window closed or lose the restart.
- Triggers held high while disarmed, inhibited, or outside the window. A leak there would show up as an extra hold strobe or a changed map on readback.

// File: rtl/evcol_pkg.sv
package evcol_pkg;

    localparam int CH_DEF    = 36;
    localparam int COL_DEF   = 16;
    localparam int STAMP_DEF = 12;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ARMED,
        CS_WAIT_BX,
        CS_SAT
    } ctl_state_t;

    typedef struct packed {
        logic open;
        logic close;
        logic tick;
    } win_cmd_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/evcol_bx_counter.sv
module evcol_bx_counter #(
    parameter int STAMP_W = evcol_pkg::STAMP_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               advance,
    output logic [STAMP_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count + STAMP_W'(1);
        end
    end
endmodule

// File: rtl/evcol_alloc.sv
module evcol_alloc
    import evcol_pkg::*;
#(
    parameter int N_COL = COL_DEF,
    parameter int PTR_W = idx_width(N_COL),
    parameter int CNT_W = $clog2(N_COL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  win_cmd_t         cmd,
    input  logic             any_trig,
    input  logic             no_trig,
    output logic             fire,
    output logic [PTR_W-1:0] wr_col,
    output logic             active,
    output logic             armed,
    output logic             full,
    output logic             hold_strobe,
    output logic [PTR_W-1:0] hold_col,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    ctl_state_t state_q, state_d;
    logic       last_col;
    logic       closing;

    assign active   = (state_q != CS_IDLE);
    assign armed    = (state_q == CS_ARMED);
    assign full     = (state_q == CS_SAT);
    assign closing  = cmd.close && active && !cmd.open;
    assign fire     = armed && !cmd.open && !cmd.close && any_trig && !no_trig;
    assign wr_col   = count[PTR_W-1:0];
    assign last_col = (count == CNT_W'(N_COL - 1));

    always_comb begin
        state_d = state_q;
        if (cmd.open) begin
            state_d = CS_ARMED;
        end else if (closing) begin
            state_d = CS_IDLE;
        end else begin
            unique case (state_q)
                CS_ARMED:   if (fire) state_d = last_col ? CS_SAT : CS_WAIT_BX;
                CS_WAIT_BX: if (cmd.tick) state_d = CS_ARMED;
                default:    state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CS_IDLE;
            count       <= '0;
            hold_strobe <= 1'b0;
            hold_col    <= '0;
            done        <= 1'b0;
        end else begin
            state_q     <= state_d;
            hold_strobe <= fire;
            done        <= closing;
            if (cmd.open) begin
                count <= '0;
            end else if (fire) begin
                count <= count + CNT_W'(1);
            end
            if (fire) begin
                hold_col <= wr_col;
            end
        end
    end
endmodule

// File: rtl/evcol_store.sv
module evcol_store #(
    parameter int N_CH    = evcol_pkg::CH_DEF,
    parameter int N_COL   = evcol_pkg::COL_DEF,
    parameter int STAMP_W = evcol_pkg::STAMP_DEF,
    parameter int PTR_W   = evcol_pkg::idx_width(N_COL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_col,
    input  logic [N_CH-1:0]    wr_hits,
    input  logic [STAMP_W-1:0] wr_stamp,
    input  logic [PTR_W-1:0]   rd_col,
    output logic [N_CH-1:0]    rd_hits,
    output logic [STAMP_W-1:0] rd_stamp
);
    logic [N_CH-1:0]    map_q   [N_COL];
    logic [STAMP_W-1:0] stamp_q [N_COL];

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                map_q[c]   <= '0;
                stamp_q[c] <= '0;
            end else if (wr_en && (wr_col == PTR_W'(c))) begin
                map_q[c]   <= wr_hits;
                stamp_q[c] <= wr_stamp;
            end
        end
    end

    always_comb begin
        rd_hits  = '0;
        rd_stamp = '0;
        for (int c = 0; c < N_COL; c++) begin
            if (rd_col == PTR_W'(c)) begin
                rd_hits  = map_q[c];
                rd_stamp = stamp_q[c];
            end
        end
    end
endmodule

// File: rtl/evcol_acq_ctrl.sv
module evcol_acq_ctrl
    import evcol_pkg::*;
#(
    parameter int N_CH    = CH_DEF,
    parameter int N_COL   = COL_DEF,
    parameter int STAMP_W = STAMP_DEF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             acq_start,
    input  logic                             acq_stop,
    input  logic                             no_trig,
    input  logic                             bx_tick,
    input  logic [N_CH-1:0]                  trig_in,
    input  logic [idx_width(N_COL)-1:0]      rd_col,
    output logic                             acq_active,
    output logic                             armed,
    output logic                             full,
    output logic                             hold_strobe,
    output logic [idx_width(N_COL)-1:0]      hold_col,
    output logic [$clog2(N_COL+1)-1:0]       cols_used,
    output logic                             acq_done,
    output logic [N_CH-1:0]                  rd_hits,
    output logic [STAMP_W-1:0]               rd_stamp
);
    localparam int PTR_W = idx_width(N_COL);
    localparam int CNT_W = $clog2(N_COL + 1);

    win_cmd_t           cmd;
    logic               any_trig;
    logic               fire;
    logic [PTR_W-1:0]   wr_col;
    logic [STAMP_W-1:0] bx_count;

    assign cmd      = '{open: acq_start, close: acq_stop, tick: bx_tick};
    assign any_trig = |trig_in;

    evcol_alloc #(.N_COL(N_COL), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_alloc (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .any_trig   (any_trig),
        .no_trig    (no_trig),
        .fire       (fire),
        .wr_col     (wr_col),
        .active     (acq_active),
        .armed      (armed),
        .full       (full),
        .hold_strobe(hold_strobe),
        .hold_col   (hold_col),
        .count      (cols_used),
        .done       (acq_done)
    );

    evcol_bx_counter #(.STAMP_W(STAMP_W)) u_bx (
        .clk    (clk),
        .rst    (rst),
        .clear  (acq_start),
        .advance(bx_tick && acq_active),
        .count  (bx_count)
    );

    evcol_store #(.N_CH(N_CH), .N_COL(N_COL), .STAMP_W(STAMP_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (acq_start),
        .wr_en   (fire),
        .wr_col  (wr_col),
        .wr_hits (trig_in),
        .wr_stamp(bx_count),
        .rd_col  (rd_col),
        .rd_hits (rd_hits),
        .rd_stamp(rd_stamp)
    );
endmodule

// File: rtl/evcol_acq_ctrl_chk.sv
module evcol_acq_ctrl_chk #(
    parameter int N_CH  = 36,
    parameter int N_COL = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          acq_start,
    input logic                          no_trig,
    input logic                          bx_tick,
    input logic [N_CH-1:0]               trig_in,
    input logic                          acq_active,
    input logic                          armed,
    input logic                          full,
    input logic                          hold_strobe,
    input logic [evcol_pkg::idx_width(N_COL)-1:0] hold_col,
    input logic [$clog2(N_COL+1)-1:0]    cols_used,
    input logic                          acq_done
);
    localparam int CNT_W = $clog2(N_COL + 1);

    assert_hold_single_R1: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |=> !hold_strobe);
    assert_hold_needs_trig_R1: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> $past(|trig_in));
    assert_hold_col_order_R2: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> (CNT_W'(hold_col) + CNT_W'(1) == cols_used));
    assert_capture_disarms_R5: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> !armed);
    assert_rearm_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(bx_tick) || $past(acq_start)));
    assert_full_no_arm_R6: assert property (@(posedge clk) disable iff (rst)
        full |-> !armed);
    assert_inhibit_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> !$past(no_trig));
    assert_idle_no_arm_R8: assert property (@(posedge clk) disable iff (rst)
        !acq_active |-> !armed);
    assert_done_closes_R9: assert property (@(posedge clk) disable iff (rst)
        acq_done |-> !acq_active);
endmodule

bind evcol_acq_ctrl evcol_acq_ctrl_chk #(.N_CH(N_CH), .N_COL(N_COL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acq_start  (acq_start),
    .no_trig    (no_trig),
    .bx_tick    (bx_tick),
    .trig_in    (trig_in),
    .acq_active (acq_active),
    .armed      (armed),
    .full       (full),
    .hold_strobe(hold_strobe),
    .hold_col   (hold_col),
    .cols_used  (cols_used),
    .acq_done   (acq_done)
);

// File: tb/test_evcol_acq_ctrl.sv
module test_evcol_acq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 36;
    localparam int NCOL = 16;
    localparam int SW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acq_start = 0, acq_stop = 0, no_trig = 0, bx_tick = 0;
    logic [NCH-1:0] trig_in = '0;
    logic [3:0] rd_col = '0;
    logic acq_active, armed, full, hold_strobe, acq_done;
    logic [3:0] hold_col;
    logic [4:0] cols_used;
    logic [NCH-1:0] rd_hits;
    logic [SW-1:0] rd_stamp;

    always #(CLK_PERIOD/2) clk = ~clk;

    evcol_acq_ctrl i_evcol_acq_ctrl (
        .clk(clk), .rst(rst), .acq_start(acq_start), .acq_stop(acq_stop),
        .no_trig(no_trig), .bx_tick(bx_tick), .trig_in(trig_in), .rd_col(rd_col),
        .acq_active(acq_active), .armed(armed), .full(full), .hold_strobe(hold_strobe),
        .hold_col(hold_col), .cols_used(cols_used), .acq_done(acq_done),
        .rd_hits(rd_hits), .rd_stamp(rd_stamp)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string ph = "R10 reset";

    // reference state
    bit m_active, m_armed, m_hold, m_done;
    int m_count, m_holdcol;
    logic [SW-1:0] m_bx;
    logic [NCH-1:0] m_map [NCOL];
    logic [SW-1:0] m_stamp [NCOL];
    int lcg = 12345;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", ph, tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R8 acq_active", 64'(acq_active), 64'(m_active));
        chk("R5 armed", 64'(armed), 64'(m_armed));
        chk("R6 full", 64'(full), 64'(m_active && m_count == NCOL));
        chk("R1 hold_strobe", 64'(hold_strobe), 64'(m_hold));
        chk("R2 hold_col", 64'(hold_col), 64'(m_holdcol));
        chk("R2 cols_used", 64'(cols_used), 64'(m_count));
        chk("R9 acq_done", 64'(acq_done), 64'(m_done));
        chk("R3 rd_hits", 64'(rd_hits), 64'(m_map[rd_col]));
        chk("R4 rd_stamp", 64'(rd_stamp), 64'(m_stamp[rd_col]));
    endtask

    task automatic model_reset();
        m_active = 0; m_armed = 0; m_hold = 0; m_done = 0;
        m_count = 0; m_holdcol = 0; m_bx = '0;
        for (int c = 0; c < NCOL; c++) begin m_map[c] = '0; m_stamp[c] = '0; end
    endtask

    task automatic model_step(input bit st, input bit sp, input bit nt, input bit tk,
                              input logic [NCH-1:0] tr);
        bit was_active = m_active;
        m_hold = 0; m_done = 0;
        if (st) begin
            m_active = 1; m_armed = 1; m_count = 0; m_bx = '0;
            for (int c = 0; c < NCOL; c++) begin m_map[c] = '0; m_stamp[c] = '0; end
        end else if (m_active && sp) begin
            m_active = 0; m_armed = 0; m_done = 1;
            if (tk) m_bx = m_bx + 1'b1;
        end else if (m_active) begin
            if (m_armed && !nt && m_count < NCOL && tr != '0) begin
                m_map[m_count] = tr; m_stamp[m_count] = m_bx;
                m_hold = 1; m_holdcol = m_count; m_count++; m_armed = 0;
            end else if (!m_armed && m_count < NCOL && tk) begin
                m_armed = 1;
            end
            if (tk && was_active) m_bx = m_bx + 1'b1;
        end
    endtask

    task automatic cyc(input bit st, input bit sp, input bit nt, input bit tk,
                       input logic [NCH-1:0] tr);
        @(negedge clk);
        compare_all();
        acq_start = st; acq_stop = sp; no_trig = nt; bx_tick = tk; trig_in = tr;
        rd_col = rd_col + 4'd1;
        model_step(st, sp, nt, tk, tr);
    endtask

    function automatic logic [NCH-1:0] rnd_trig();
        logic [63:0] v;
        lcg = lcg * 1103515245 + 12345;
        v[31:0] = 32'(lcg);
        lcg = lcg * 1103515245 + 12345;
        v[63:32] = 32'(lcg);
        return v[NCH-1:0];
    endfunction

    function automatic int rnd(input int m);
        lcg = lcg * 1103515245 + 12345;
        return ((lcg >>> 8) & 32'h7fff) % m;
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        ph = "R10 reset";
        chk("R10 active", 64'(acq_active), 0);
        chk("R10 armed", 64'(armed), 0);
        chk("R10 cols_used", 64'(cols_used), 0);
        chk("R10 hits", 64'(rd_hits), 0);
        // triggers before any window
        ph = "R8 pre-window";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, i[0], rnd_trig());
        // open and capture single channel, tick same cycle as capture
        ph = "R1 R5 capture/rearm";
        cyc(1, 0, 0, 0, '0);
        cyc(0, 0, 0, 1, NCH'(1) << 35);
        cyc(0, 0, 0, 0, NCH'(1));
        cyc(0, 0, 0, 0, NCH'(3));
        cyc(0, 0, 0, 1, NCH'(5));
        cyc(0, 0, 0, 0, NCH'(7));
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, rnd(3) == 0, rnd(2) ? rnd_trig() : '0);
        // inhibit
        ph = "R7 no_trig";
        for (int i = 0; i < 12; i++) cyc(0, 0, 1, i[0], rnd_trig());
        chk("R7 count frozen", 64'(cols_used), 64'(m_count));
        // fill to saturation and beyond
        ph = "R6 saturate";
        for (int i = 0; i < 60; i++) cyc(0, 0, 0, i[0], rnd_trig() | NCH'(1));
        chk("R6 full after fill", 64'(full), 1);
        // close with trigger present
        ph = "R9 stop";
        cyc(0, 1, 0, 1, rnd_trig());
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, rnd_trig());
        chk("R9 count kept", 64'(cols_used), 64'(NCOL));
        // restart, few events, start+stop same cycle
        ph = "R2 restart";
        cyc(1, 0, 0, 0, '1);
        cyc(0, 0, 0, 0, NCH'(9));
        cyc(0, 0, 0, 1, '0);
        cyc(0, 0, 0, 0, NCH'(2));
        cyc(0, 1, 0, 0, '0);
        cyc(1, 1, 0, 0, NCH'(4));
        cyc(0, 0, 0, 0, NCH'(4));
        cyc(0, 1, 0, 1, NCH'(4));
        // random mix
        ph = "R1 random";
        for (int i = 0; i < 2000; i++)
            cyc(rnd(150) == 0, rnd(120) == 0, rnd(10) == 0, rnd(3) == 0,
                rnd(3) != 0 ? rnd_trig() : '0);
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule